// File: doc/BRIEF.md
# Parallel NAND Host Cycle Sequencer

This block sits on the host side of an asynchronous 8-bit parallel NAND flash bus. An internal client hands it one request at a time: send a command byte, send an address sequence, write one data byte, or read one data byte. The block converts each request into bus cycles on the chip-enable, command-latch, address-latch, write-strobe, read-strobe and write-protect lines, and drives or samples the 8-bit I/O lanes.

Every bus byte is split into three phases: setup, strobe low and hold. Each phase lasts `cfg_tim + 1` system clocks. Address requests send 4 or 5 bytes, chosen by a configuration input, lowest byte first. The write-protect line is released (driven high) only while the most recent command belongs to the program/erase group. `busy` covers a request from acceptance to completion, and `done` pulses once at the end. Between requests the bus goes back to standby with chip enable high.

Top module: `pnseq_top`

## Requirements
- R1: After reset, nand_ce_n=1, nand_we_n=1, nand_re_n=1, nand_cle=0, nand_ale=0, io_oe=0, nand_wp_n=0, busy=0 and done=0.
- R2: A request with req_op=0 (command) produces exactly one nand_we_n rising edge. At that edge nand_ce_n=0, nand_cle=1, nand_ale=0, nand_re_n=1, io_oe=1 and io_out=req_byte.
- R3: A request with req_op=1 (address) produces 4 nand_we_n rising edges when cfg_five_addr=0 and 5 when it is 1. At each edge nand_ale=1 and nand_cle=0. Byte k carries req_addr[8k+7:8k], starting from k=0.
- R4: A request with req_op=2 (data in) produces one nand_we_n rising edge with nand_cle=0, nand_ale=0, nand_re_n=1 and io_out=req_byte.
- R5: A request with req_op=3 (data out) holds nand_we_n high and produces one nand_re_n low pulse. io_oe is 0 while nand_re_n is low and in the clock before it falls. rd_data takes the io_in value present at the clock on which nand_re_n returns high.
- R6: Each nand_we_n or nand_re_n low pulse lasts cfg_tim+1 clocks.
- R7: After a command whose byte is 0x80, 0x85, 0x60, 0x10 or 0xD0, nand_wp_n is 1. After any other command it is 0. It changes when the command is accepted, so it is stable while nand_we_n is low. Non-command requests leave it unchanged.
- R8: busy is 1 from the clock after acceptance until completion. done is a single-clock pulse with busy=0. Requests presented while busy are ignored. nand_ce_n returns to 1 when a request ends.
- R9: nand_we_n and nand_re_n are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 0 command, 1 address, 2 data in, 3 data out |
| req_byte | input | 8 | Command or write-data byte |
| req_addr | input | 40 | Address bytes, lowest byte sent first |
| cfg_five_addr | input | 1 | 1 selects 5 address cycles, 0 selects 4 |
| cfg_tim | input | 4 | Phase length minus one, in clocks |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Last byte read from the device |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| io_out | output | 8 | Byte driven onto the I/O lanes |
| io_oe | output | 1 | Output enable for io_out |
| io_in | input | 8 | Byte sampled from the I/O lanes |

## Verification
The vector walk runs every request kind at several phase lengths. This separates latch-line decoding (command vs. address vs. data), strobe pulse width, and byte order inside a 4- or 5-byte address sequence. The command bytes mix members of the program/erase group with ordinary commands, and address and data requests sit between them, so the write-protect level shows whether it tracks only command requests. Each read uses a different io_in pattern, which is driven only while the read strobe is low, so a sample taken at the wrong clock is caught. A request presented while busy must leave the bus untouched.

// File: rtl/pnseq_pkg.sv
// Shared types for the NAND cycle sequencer.
// Assumes: 8-bit command codes; the program/erase command group is fixed.
package pnseq_pkg;
    typedef enum logic [1:0] {
        OP_CMD   = 2'd0,
        OP_ADDR  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    // True for commands that start or confirm a program or erase.
    function automatic logic is_modify(input logic [7:0] code);
        return code inside {8'h80, 8'h85, 8'h60, 8'h10, 8'hD0};
    endfunction
endpackage

// File: rtl/pnseq_timer.sv
// Phase timer: counts down from a loaded value and flags zero.
// Assumes: load takes priority; stays at zero until reloaded.
module pnseq_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Down-counter for the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/pnseq_byte_seq.sv
// Byte sequencer: holds the bytes of one request and presents them
// lowest first, flagging the last one.
// Assumes: count_in is at least 1 and at most NBYTE.
module pnseq_byte_seq #(
    parameter int NBYTE = 5,
    localparam int BW = 8 * NBYTE,
    localparam int CW = $clog2(NBYTE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic [BW-1:0] bytes_in,
    input  logic [CW-1:0] count_in,
    output logic [7:0]    cur_byte,
    output logic          last
);
    logic [BW-1:0] shreg;
    logic [CW-1:0] idx;
    logic [CW-1:0] count;

    // Load the request bytes, then shift one byte per advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            idx   <= '0;
            count <= CW'(1);
        end else if (load) begin
            shreg <= bytes_in;
            idx   <= '0;
            count <= count_in;
        end else if (adv) begin
            shreg <= shreg >> 8;
            idx   <= idx + 1'b1;
        end
    end

    assign cur_byte = shreg[7:0];
    assign last     = (CW'(idx + 1'b1) == count);
endmodule

// File: rtl/pnseq_wp_ctl.sv
// Write-protect tracker: releases protection only after a command
// from the program/erase group, re-arms it on any other command.
// Assumes: cmd_accept pulses once per accepted command request.
module pnseq_wp_ctl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_accept,
    input  logic [7:0] cmd_byte,
    output logic       wp_n
);
    import pnseq_pkg::*;

    // Update the protect level when a command is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wp_n <= 1'b0;
        else if (cmd_accept)
            wp_n <= is_modify(cmd_byte);
    end
endmodule

// File: rtl/pnseq_top.sv
// NAND host cycle sequencer top: accepts one request at a time and
// plays it out as setup / strobe / hold phases on the NAND bus.
// Assumes: io_out/io_oe drive an external tristate; io_in is stable
// while the read strobe is low; the bus idles in standby.
module pnseq_top #(
    parameter int TIM_W      = 4,
    parameter int ADDR_BYTES = 5,
    localparam int ADDR_W    = 8 * ADDR_BYTES,
    localparam int CW        = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [7:0]        req_byte,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              cfg_five_addr,
    input  logic [TIM_W-1:0]  cfg_tim,
    output logic              busy,
    output logic              done,
    output logic [7:0]        rd_data,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic              nand_wp_n,
    output logic [7:0]        io_out,
    output logic              io_oe,
    input  logic [7:0]        io_in
);
    import pnseq_pkg::*;

    phase_e            phase;
    op_e               op_q;
    logic              accept;
    logic              expired;
    logic              tmr_load;
    logic              last;
    logic              adv;
    logic [ADDR_W-1:0] seq_bytes;
    logic [CW-1:0]     seq_count;

    assign accept   = (phase == PH_IDLE) && req_valid;
    assign tmr_load = accept || ((phase != PH_IDLE) && expired);
    assign adv      = (phase == PH_HOLD) && expired && !last;
    assign busy     = (phase != PH_IDLE);

    // Pick the byte list and its length for the incoming request.
    always_comb begin
        if (op_e'(req_op) == OP_ADDR) begin
            seq_bytes = req_addr;
            seq_count = cfg_five_addr ? CW'(ADDR_BYTES) : CW'(ADDR_BYTES - 1);
        end else begin
            seq_bytes = ADDR_W'(req_byte);
            seq_count = CW'(1);
        end
    end

    pnseq_timer #(.W(TIM_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (cfg_tim),
        .expired  (expired)
    );

    pnseq_byte_seq #(.NBYTE(ADDR_BYTES)) u_bytes (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .adv      (adv),
        .bytes_in (seq_bytes),
        .count_in (seq_count),
        .cur_byte (io_out),
        .last     (last)
    );

    pnseq_wp_ctl u_wp (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_accept (accept && (op_e'(req_op) == OP_CMD)),
        .cmd_byte   (req_byte),
        .wp_n       (nand_wp_n)
    );

    // Phase sequencing and registered bus strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            op_q      <= OP_CMD;
            nand_ce_n <= 1'b1;
            nand_cle  <= 1'b0;
            nand_ale  <= 1'b0;
            nand_we_n <= 1'b1;
            nand_re_n <= 1'b1;
            io_oe     <= 1'b0;
            done      <= 1'b0;
            rd_data   <= '0;
        end else begin
            done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        op_q      <= op_e'(req_op);
                        nand_ce_n <= 1'b0;
                        nand_cle  <= (op_e'(req_op) == OP_CMD);
                        nand_ale  <= (op_e'(req_op) == OP_ADDR);
                        io_oe     <= (op_e'(req_op) != OP_READ);
                        phase     <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (expired) begin
                        phase <= PH_STROBE;
                        if (op_q == OP_READ)
                            nand_re_n <= 1'b0;
                        else
                            nand_we_n <= 1'b0;
                    end
                end
                PH_STROBE: begin
                    if (expired) begin
                        phase     <= PH_HOLD;
                        nand_we_n <= 1'b1;
                        nand_re_n <= 1'b1;
                        if (op_q == OP_READ)
                            rd_data <= io_in;
                    end
                end
                PH_HOLD: begin
                    if (expired) begin
                        if (last) begin
                            phase     <= PH_IDLE;
                            nand_ce_n <= 1'b1;
                            nand_cle  <= 1'b0;
                            nand_ale  <= 1'b0;
                            io_oe     <= 1'b0;
                            done      <= 1'b1;
                        end else begin
                            phase <= PH_SETUP;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pnseq_chk.sv
// Property checker for the NAND cycle sequencer, bound to pnseq_top.
// Assumes: synchronous active-low reset on rst_n.
module pnseq_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic nand_ce_n,
    input logic nand_cle,
    input logic nand_ale,
    input logic nand_we_n,
    input logic nand_re_n,
    input logic nand_wp_n,
    input logic io_oe
);
    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> nand_re_n);

    // R5
    read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !io_oe);

    // R5
    read_release_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_re_n) |-> !$past(io_oe));

    // R2
    we_selects_chip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> (!nand_ce_n && io_oe));

    // R3
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nand_ale |-> !nand_cle);

    // R7
    wp_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> $stable(nand_wp_n));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (nand_ce_n && nand_we_n && nand_re_n));
endmodule

bind pnseq_top pnseq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .nand_ce_n (nand_ce_n),
    .nand_cle  (nand_cle),
    .nand_ale  (nand_ale),
    .nand_we_n (nand_we_n),
    .nand_re_n (nand_re_n),
    .nand_wp_n (nand_wp_n),
    .io_oe     (io_oe)
);

// File: tb/test_pnseq_top.sv
module test_pnseq_top;
    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  dat;
        logic [39:0] adr;
        logic        five;
        logic [3:0]  tim;
        logic [2:0]  n_we;
        logic        n_re;
        logic        wp;
    } vec_t;

    localparam logic [39:0] A1 = 40'h55_44_33_22_11;
    localparam logic [39:0] A2 = 40'hE5_D4_C3_B2_A1;
    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'hFF, 40'h0, 1'b0, 4'd0, 3'd1, 1'b0, 1'b0},
        '{2'd0, 8'h80, 40'h0, 1'b0, 4'd2, 3'd1, 1'b0, 1'b1},
        '{2'd1, 8'h00, A1,    1'b0, 4'd1, 3'd4, 1'b0, 1'b1},
        '{2'd1, 8'h00, A2,    1'b1, 4'd0, 3'd5, 1'b0, 1'b1},
        '{2'd2, 8'hA5, 40'h0, 1'b0, 4'd3, 3'd1, 1'b0, 1'b1},
        '{2'd0, 8'h10, 40'h0, 1'b0, 4'd0, 3'd1, 1'b0, 1'b1},
        '{2'd3, 8'h00, 40'h0, 1'b0, 4'd1, 3'd0, 1'b1, 1'b1},
        '{2'd0, 8'h00, 40'h0, 1'b0, 4'd1, 3'd1, 1'b0, 1'b0},
        '{2'd1, 8'h00, A1,    1'b1, 4'd2, 3'd5, 1'b0, 1'b0},
        '{2'd3, 8'h00, 40'h0, 1'b0, 4'd0, 3'd0, 1'b1, 1'b0},
        '{2'd0, 8'h60, 40'h0, 1'b0, 4'd4, 3'd1, 1'b0, 1'b1},
        '{2'd0, 8'h70, 40'h0, 1'b0, 4'd0, 3'd1, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [7:0]  req_byte = '0;
    logic [39:0] req_addr = '0;
    logic        cfg_five_addr = 1'b0;
    logic [3:0]  cfg_tim = '0;
    logic        busy, done, nand_ce_n, nand_cle, nand_ale;
    logic        nand_we_n, nand_re_n, nand_wp_n, io_oe;
    logic [7:0]  rd_data, io_out, io_in;
    logic [7:0]  rd_pat = 8'h00;

    int total = 0;
    int bad = 0;
    int we_rises, re_rises, we_run, re_run;
    int strobe_bad, width_bad, oe_bad, excl_bad;
    logic [7:0] log_b [8];
    logic       log_cle [8];
    logic       log_ale [8];
    logic prev_we = 1'b1, prev_re = 1'b1, prev_oe = 1'b0;

    always #2.5 clk = ~clk;

    // Device model: drives the read pattern only while RE# is low.
    assign io_in = nand_re_n ? 8'h00 : rd_pat;

    pnseq_top i_pnseq_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_byte(req_byte), .req_addr(req_addr), .cfg_five_addr(cfg_five_addr),
        .cfg_tim(cfg_tim), .busy(busy), .done(done), .rd_data(rd_data),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n),
        .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    // Bus monitor: records WE# rising edges and strobe widths at negedges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!nand_we_n) we_run = we_run + 1;
            if (!nand_re_n) re_run = re_run + 1;
            if (nand_we_n && !prev_we) begin
                if (we_rises < 8) begin
                    log_b[we_rises]   = io_out;
                    log_cle[we_rises] = nand_cle;
                    log_ale[we_rises] = nand_ale;
                end
                if (nand_ce_n || !nand_re_n || !io_oe) strobe_bad = strobe_bad + 1;
                if (we_run != int'(cfg_tim) + 1) width_bad = width_bad + 1;
                we_rises = we_rises + 1;
                we_run = 0;
            end
            if (nand_re_n && !prev_re) begin
                if (re_run != int'(cfg_tim) + 1) width_bad = width_bad + 1;
                re_rises = re_rises + 1;
                re_run = 0;
            end
            if (!nand_re_n && (io_oe || (prev_re && prev_oe))) oe_bad = oe_bad + 1;
            if (!nand_we_n && !nand_re_n) excl_bad = excl_bad + 1;
            prev_we = nand_we_n;
            prev_re = nand_re_n;
            prev_oe = io_oe;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        we_rises = 0; re_rises = 0; we_run = 0; re_run = 0;
        strobe_bad = 0; width_bad = 0; oe_bad = 0; excl_bad = 0;
    endtask

    task automatic wait_done();
        for (int g = 0; g < 2000 && !done; g++) @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] op, input logic [7:0] b, input logic [39:0] a,
                         input logic five, input logic [3:0] t);
        @(negedge clk);
        clear_mon();
        req_op = op; req_byte = b; req_addr = a; cfg_five_addr = five; cfg_tim = t;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #500000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_mon();
        repeat (2) @(negedge clk);
        // R1: reset state
        chk(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale,
            "R1 strobes", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale}, 5'b11100);
        chk(!io_oe && !nand_wp_n && !busy && !done, "R1 oe/wp/busy",
            {io_oe, nand_wp_n, busy, done}, 4'b0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            rd_pat = 8'h3C ^ 8'(i * 37);
            issue(VECS[i].op, VECS[i].dat, VECS[i].adr, VECS[i].five, VECS[i].tim);
            chk(busy == 1'b1, "R8 busy after accept", busy, 1);
            wait_done();
            chk(done && !busy, "R8 done pulse", {done, busy}, 2'b10);
            chk(we_rises == int'(VECS[i].n_we), "R2 R3 R4 WE rise count", we_rises, VECS[i].n_we);
            chk(re_rises == int'(VECS[i].n_re), "R5 RE pulse count", re_rises, VECS[i].n_re);
            chk(width_bad == 0, "R6 strobe width", width_bad, 0);
            chk(strobe_bad == 0 && excl_bad == 0, "R9 strobe levels at WE edge",
                strobe_bad + excl_bad, 0);
            chk(nand_wp_n == VECS[i].wp, "R7 write protect level", nand_wp_n, VECS[i].wp);
            for (int k = 0; k < int'(VECS[i].n_we) && k < 8; k++) begin
                case (VECS[i].op)
                    2'd0: chk(log_b[k] == VECS[i].dat && log_cle[k] && !log_ale[k],
                              "R2 command byte", {log_cle[k], log_ale[k], log_b[k]},
                              {2'b10, VECS[i].dat});
                    2'd1: chk(log_b[k] == 8'(VECS[i].adr >> (8 * k)) && !log_cle[k] && log_ale[k],
                              "R3 address byte", {log_cle[k], log_ale[k], log_b[k]},
                              {2'b01, 8'(VECS[i].adr >> (8 * k))});
                    default: chk(log_b[k] == VECS[i].dat && !log_cle[k] && !log_ale[k],
                              "R4 data byte", {log_cle[k], log_ale[k], log_b[k]},
                              {2'b00, VECS[i].dat});
                endcase
            end
            if (VECS[i].op == 2'd3) begin
                chk(rd_data == rd_pat, "R5 read sample", rd_data, rd_pat);
                chk(oe_bad == 0, "R5 output released before RE low", oe_bad, 0);
            end
            @(negedge clk);
            chk(!done && nand_ce_n, "R8 single done and standby", {done, nand_ce_n}, 2'b01);
        end

        // R8: a request presented while busy is ignored
        issue(2'd0, 8'h70, 40'h0, 1'b0, 4'd3);
        repeat (2) @(negedge clk);
        req_op = 2'd2; req_byte = 8'h99; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_done();
        repeat (20) @(negedge clk);
        chk(we_rises == 1 && log_b[0] == 8'h70 && log_cle[0], "R8 busy request ignored",
            {we_rises[3:0], log_b[0]}, {4'd1, 8'h70});
        chk(!busy && nand_ce_n, "R8 idle in standby", {busy, nand_ce_n}, 2'b01);

        // R7: address request after an ordinary command keeps protection
        issue(2'd1, 8'h00, A2, 1'b0, 4'd0);
        wait_done();
        chk(!nand_wp_n && we_rises == 4, "R7 R3 protect kept over address",
            {nand_wp_n, we_rises[3:0]}, {1'b0, 4'd4});

        // R1: reset mid-request returns the bus to its reset state
        issue(2'd2, 8'h5A, 40'h0, 1'b0, 4'd5);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(nand_ce_n && nand_we_n && !busy && !io_oe, "R1 reset mid request",
            {nand_ce_n, nand_we_n, busy, io_oe}, 4'b1100);
        rst_n = 1'b1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule